// File: doc/BRIEF.md
# Non-Overlapping Pulse Output Register

This block is the output stage of a multi-bit pulse port. Software loads a pattern into a staging register, and two strobes from an outside timer move that pattern into the output register that drives the pins. Strobe A copies every enabled bit. Strobe B copies only the enabled bits whose staged value is 0. When B is timed before A, every falling edge reaches the pins before any rising edge. The time between B and A is therefore a guaranteed gap, so two complementary outputs are never high together.

Each pin is driven only when both its transfer-enable bit and its direction bit are set. The driven value can be inverted by a control bit. Strobe A also produces a one-cycle request, which is meant to trigger the reload of the staging register by an interrupt handler or a DMA channel. A sticky flag records any reload that falls inside the B-to-A gap, where a reload would break the gap. Software clears the flag.

Top module: `nolap_pulse_out`

## Requirements
- R1: While `rst_n` is low at a clock edge, the staging, output, enable and direction registers are cleared, along with the invert bit and the gap-violation flag. After reset `pin_oe`, `pin_out`, `gap_err` and `xfer_req` all read 0.
- R2: When `cmp_a` is high at a clock edge, each bit with its enable bit set takes its staged value, whether that value is 0 or 1. The result appears on the pins after that edge.
- R3: When `cmp_b` is high and `cmp_a` is low, each enabled bit whose staged value is 0 is cleared. Each enabled bit whose staged value is 1 keeps its present output value.
- R4: When `cmp_a` and `cmp_b` are high in the same cycle, strobe A governs and every enabled bit takes its staged value.
- R5: A bit whose enable bit is 0 keeps its output register value through both strobes. The kept value shows on its pin once the bit is enabled again.
- R6: A write to the staging register in the same cycle as a strobe has no effect on that strobe, which transfers the previous staged value. The new value is used from the next strobe on.
- R7: `pin_oe` is the AND of the enable register and the direction register. `pin_out` is 0 on every bit that is not driven.
- R8: Control bit 0 set to 1 drives every driven pin with the inverse of its output register bit. Set to 0, it drives the bit unchanged.
- R9: `xfer_req` is high for exactly the one cycle that follows each clock edge at which `cmp_a` was high.
- R10: The gap opens at a `cmp_b`-only edge and closes at a `cmp_a` edge. A staging write while the gap is open, and not in the same cycle as `cmp_a`, sets `gap_err`. A write in the same cycle as the opening `cmp_b`, or a write after `cmp_a`, leaves `gap_err` unchanged.
- R11: A control write with bit 1 set clears `gap_err`, unless a gap violation sets it in the same cycle. Register select values are: 0 for staging, 1 for enable, 2 for direction, 3 for control.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 staging, 1 enable, 2 direction, 3 control |
| wr_data | input | WIDTH | Write data; for control, bit 0 is invert and bit 1 clears the flag |
| cmp_a | input | 1 | Full-transfer strobe from the timer |
| cmp_b | input | 1 | Zero-only transfer strobe from the timer |
| pin_out | output | WIDTH | Pin data |
| pin_oe | output | WIDTH | Per-pin drive enable |
| xfer_req | output | 1 | One-cycle reload request after strobe A |
| gap_err | output | 1 | Sticky flag for a staging write inside the B-to-A gap |

## Verification
The hardest case to reach is a bit that holds a value while its enable bit is 0. The pins show nothing for that bit until it is enabled again. The bench therefore strobes with a partial enable mask and then restores the full mask with no strobe in between, so the held value becomes visible on the pins. The gap flag also needs exact cycle placement. The bench drives a staging write in the same cycle as `cmp_b`, a write between the two strobes, and a write after `cmp_a`, and it expects the flag to change for only one of the three.

// File: rtl/nopo_pkg.sv
// Package: shared register selects and control-bit positions for the
// non-overlapping pulse output block. Assumes WIDTH >= 2 at the top.
package nopo_pkg;
    typedef enum logic [1:0] {
        SEL_NEXT = 2'd0,
        SEL_EN   = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam int CTRL_INV_BIT = 0;
    localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/nopo_regs.sv
// Module: software-visible registers (staging data, enable, direction,
// invert). Decodes the write bus and produces one-cycle pulses for a
// staging write and a flag-clear request. Assumes WIDTH >= 2.
module nopo_regs
    import nopo_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] next_q,
    output logic [WIDTH-1:0] en_q,
    output logic [WIDTH-1:0] dir_q,
    output logic             inv_q,
    output logic             next_wr,
    output logic             clr_req
);
    reg_sel_e sel;

    // Decode the register select and the write pulses.
    always_comb begin
        sel     = reg_sel_e'(wr_addr);
        next_wr = wr_en && (sel == SEL_NEXT);
        clr_req = wr_en && (sel == SEL_CTRL) && wr_data[CTRL_CLR_BIT];
    end

    // Hold the staging register; a write lands at the edge after it is issued.
    always_ff @(posedge clk) begin
        if (!rst_n)       next_q <= '0;
        else if (next_wr) next_q <= wr_data;
    end

    // Hold the enable and direction masks and the invert bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            dir_q <= '0;
            inv_q <= 1'b0;
        end else if (wr_en) begin
            if (sel == SEL_EN)   en_q  <= wr_data;
            if (sel == SEL_DIR)  dir_q <= wr_data;
            if (sel == SEL_CTRL) inv_q <= wr_data[CTRL_INV_BIT];
        end
    end

    // Check that a staging write is visible one cycle later (R6).
    assert_next_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        next_wr |=> next_q == $past(wr_data));
endmodule

// File: rtl/nopo_xfer.sv
// Module: output data register with the two transfer strobes. Strobe A
// copies every enabled bit; strobe B alone clears the enabled bits whose
// staged value is 0. Disabled bits hold. Assumes single-cycle strobes.
module nopo_xfer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_a,
    input  logic             cmp_b,
    input  logic [WIDTH-1:0] next_q,
    input  logic [WIDTH-1:0] en_q,
    output logic [WIDTH-1:0] out_q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic take;

        // Decide whether this bit is updated by the strobe(s) this cycle.
        always_comb take = en_q[i] && (cmp_a || (cmp_b && !next_q[i]));

        // Update this bit of the output register.
        always_ff @(posedge clk) begin
            if (!rst_n)    out_q[i] <= 1'b0;
            else if (take) out_q[i] <= next_q[i];
        end
    end

    // After strobe A, every enabled bit equals the staged value (R2, R4).
    assert_a_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_a |=> (out_q & $past(en_q)) == ($past(next_q) & $past(en_q)));

    // After strobe B alone, staged-one bits hold their output value (R3).
    assert_b_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b && !cmp_a) |=>
            (out_q & $past(en_q & next_q)) == ($past(out_q) & $past(en_q & next_q)));

    // After strobe B alone, enabled staged-zero bits are zero (R3).
    assert_b_clears_zeros_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_b && !cmp_a) |=> (out_q & $past(en_q & ~next_q)) == '0);

    // Disabled bits never change (R5).
    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_q & ~$past(en_q)) == ($past(out_q) & ~$past(en_q)));
endmodule

// File: rtl/nopo_gap.sv
// Module: tracks the B-to-A gap, raises the sticky gap-violation flag and
// emits the one-cycle reload request after strobe A.
module nopo_gap (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_a,
    input  logic cmp_b,
    input  logic next_wr,
    input  logic clr_req,
    output logic gap_err,
    output logic xfer_req
);
    logic gap_open_q;
    logic violate;

    // A staging write while the gap is open and A is not closing it.
    always_comb violate = gap_open_q && next_wr && !cmp_a;

    // Open the gap on B alone, close it on A.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_open_q <= 1'b0;
        else if (cmp_a)          gap_open_q <= 1'b0;
        else if (cmp_b)          gap_open_q <= 1'b1;
    end

    // Sticky violation flag; setting wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       gap_err <= 1'b0;
        else if (violate) gap_err <= 1'b1;
        else if (clr_req) gap_err <= 1'b0;
    end

    // Register the reload request one cycle after strobe A.
    always_ff @(posedge clk) begin
        if (!rst_n) xfer_req <= 1'b0;
        else        xfer_req <= cmp_a;
    end

    // The request follows strobe A exactly (R9).
    assert_req_follows_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> xfer_req == $past(cmp_a));

    // The flag only falls after a clear request (R11).
    assert_flag_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gap_err) |-> $past(clr_req));

    // The flag only rises after a staging write (R10).
    assert_flag_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gap_err) |-> $past(next_wr) && !$past(cmp_a));
endmodule

// File: rtl/nopo_pins.sv
// Module: pin driver. A pin is driven when its enable and direction bits
// are both set; its value is the output bit, optionally inverted.
// Undriven pins show 0 on pin_out.
module nopo_pins #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] en_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic             inv_q,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Form the drive enable and the polarity-adjusted value for this pin.
        always_comb begin
            pin_oe[i]  = en_q[i] && dir_q[i];
            pin_out[i] = pin_oe[i] && (out_q[i] ^ inv_q);
        end
    end

    // No undriven pin carries a 1 (R7).
    assert_quiet_undriven_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
endmodule

// File: rtl/nolap_pulse_out.sv
// Module: top of the non-overlapping pulse output register. Wires the
// register file, the transfer logic, the gap tracker and the pin driver.
// Assumes WIDTH >= 2 and strobes generated synchronously to clk.
module nolap_pulse_out #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             cmp_a,
    input  logic             cmp_b,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             xfer_req,
    output logic             gap_err
);
    logic [WIDTH-1:0] next_q, en_q, dir_q, out_q;
    logic             inv_q, next_wr, clr_req;

    nopo_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .next_q(next_q), .en_q(en_q), .dir_q(dir_q),
        .inv_q(inv_q), .next_wr(next_wr), .clr_req(clr_req)
    );

    nopo_xfer #(.WIDTH(WIDTH)) u_xfer (
        .clk(clk), .rst_n(rst_n), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .next_q(next_q), .en_q(en_q), .out_q(out_q)
    );

    nopo_gap u_gap (
        .clk(clk), .rst_n(rst_n), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .next_wr(next_wr), .clr_req(clr_req), .gap_err(gap_err),
        .xfer_req(xfer_req)
    );

    nopo_pins #(.WIDTH(WIDTH)) u_pins (
        .clk(clk), .rst_n(rst_n), .out_q(out_q), .en_q(en_q), .dir_q(dir_q),
        .inv_q(inv_q), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // Reset leaves every pin released (R1).
    assert_reset_release_R1: assert property (@(posedge clk)
        !rst_n |=> pin_oe == '0);
endmodule

// File: tb/sim_nolap_pulse_out.sv
module sim_nolap_pulse_out;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         cmp_a = 1'b0;
    logic         cmp_b = 1'b0;
    logic [W-1:0] pin_out, pin_oe;
    logic         xfer_req, gap_err;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nolap_pulse_out #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .pin_out(pin_out), .pin_oe(pin_oe), .xfer_req(xfer_req),
        .gap_err(gap_err)
    );

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobe(input bit a, input bit b);
        cmp_a = a; cmp_b = b;
        @(negedge clk);
        cmp_a = 1'b0; cmp_b = 1'b0;
    endtask

    task automatic t_reset;
        check(pin_oe == 0, "R1", pin_oe, 0);
        check(pin_out == 0, "R1", pin_out, 0);
        check({7'd0, gap_err} == 0 && !xfer_req, "R1", {6'd0, xfer_req, gap_err}, 0);
    endtask

    task automatic t_enable;
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        check(pin_oe == 8'hFF, "R7", pin_oe, 8'hFF);
    endtask

    task automatic t_full;
        wr(2'd0, 8'hA5);
        strobe(1, 0);
        check(pin_out == 8'hA5, "R2", pin_out, 8'hA5);
        check(xfer_req == 1'b1, "R9", {7'd0, xfer_req}, 1);
        @(negedge clk);
        check(xfer_req == 1'b0, "R9", {7'd0, xfer_req}, 0);
    endtask

    task automatic t_zero_only;
        wr(2'd0, 8'h0F);
        strobe(0, 1);
        check(pin_out == 8'h05, "R3", pin_out, 8'h05);
        check(xfer_req == 1'b0, "R9", {7'd0, xfer_req}, 0);
        strobe(1, 0);
        check(pin_out == 8'h0F, "R2", pin_out, 8'h0F);
    endtask

    task automatic t_both;
        wr(2'd0, 8'hF0);
        strobe(1, 1);
        check(pin_out == 8'hF0, "R4", pin_out, 8'hF0);
    endtask

    task automatic t_disabled;
        wr(2'd1, 8'h0F);
        wr(2'd0, 8'h0F);
        strobe(1, 0);
        check(pin_oe == 8'h0F && pin_out == 8'h0F, "R7", pin_out, 8'h0F);
        wr(2'd0, 8'h00);
        strobe(0, 1);
        wr(2'd1, 8'hFF);
        check(pin_out == 8'hF0, "R5", pin_out, 8'hF0);
    endtask

    task automatic t_dir_inv;
        wr(2'd2, 8'h33);
        check(pin_oe == 8'h33, "R7", pin_oe, 8'h33);
        check(pin_out == 8'h30, "R7", pin_out, 8'h30);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'h01);
        check(pin_out == 8'h0F, "R8", pin_out, 8'h0F);
        wr(2'd3, 8'h00);
        check(pin_out == 8'hF0, "R8", pin_out, 8'hF0);
    endtask

    task automatic t_same_cycle;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'hAA; cmp_a = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cmp_a = 1'b0;
        check(pin_out == 8'h00, "R6", pin_out, 8'h00);
        strobe(1, 0);
        check(pin_out == 8'hAA, "R6", pin_out, 8'hAA);
    endtask

    task automatic t_gap;
        strobe(0, 1);
        check(pin_out == 8'hAA, "R3", pin_out, 8'hAA);
        wr(2'd0, 8'h55);
        check(gap_err == 1'b1, "R10", {7'd0, gap_err}, 1);
        wr(2'd3, 8'h02);
        check(gap_err == 1'b0, "R11", {7'd0, gap_err}, 0);
        strobe(1, 0);
        wr(2'd0, 8'h11);
        check(gap_err == 1'b0, "R10", {7'd0, gap_err}, 0);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h22; cmp_b = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; cmp_b = 1'b0;
        check(gap_err == 1'b0, "R10", {7'd0, gap_err}, 0);
        check(pin_out == 8'h11, "R6", pin_out, 8'h11);
        strobe(1, 0);
        check(pin_out == 8'h22, "R2", pin_out, 8'h22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_full();
        t_zero_only();
        t_both();
        t_disabled();
        t_dir_inv();
        t_same_cycle();
        t_gap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule